// File: doc/BRIEF.md
# SHA-256 Message Padding Unit

This unit sits between a 32-bit word FIFO and a SHA-256 compression engine. Message words flow through it unchanged until the word flagged as last. After that word it adds the padding on its own: a single 1 bit placed just after the final message byte, zero words as needed, and the 64-bit message bit length at the end. The padded stream is always a whole number of 512-bit blocks, and a block-end flag marks every 16th word so the engine knows when a block is complete.

Byte 0 of a word is the most significant byte, bits 31:24. The final input word carries a valid-byte count from 0 to 4. A count of 0 on the last word stands for an empty message, and its data is ignored. The bit length comes in as a separate 64-bit input. It is sampled when the last word is accepted, so an outside controller can pass any value there, for example a length that also counts a prepended 512-bit key block. While padding is being emitted the unit takes no input. Both sides use a valid/ready handshake, and every output is driven from a register.

Top module: `sha_pad_unit`

## Requirements
- R1: In the cycle after synchronous reset is released, `out_valid` is low and `in_ready` is high, given `out_ready` is high.
- R2: Every accepted word that is not the last is emitted unchanged, in order of acceptance.
- R3: A last word with a byte count n of 1, 2 or 3 is emitted with its n leading bytes (most significant first) kept. Byte n becomes 0x80 and the remaining bytes become zero, whatever the input held there (n=1 gives 0xXX800000).
- R4: A last word with byte count 4 is emitted unchanged and is followed by a separate 0x80000000 word.
- R5: An empty message (last word with byte count 0) produces 0x80000000, then 13 zero words, then two length words. The data on that input word is ignored.
- R6: Zero words follow the marker so that the length lands in word slots 14 and 15 of a block. If the marker falls in slot 14 or 15, the current block is finished with zeros and one more block is emitted that ends in the length.
- R7: The length is emitted high 32 bits first, then low 32 bits. Its value is the one on `msg_len_bits` in the cycle the last word is accepted; later changes to that input have no effect.
- R8: `out_block_end` is high on exactly every 16th word of the output stream, counted from reset, and low on all other words.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_block_end` hold their values and `out_valid` stays high.
- R10: From the cycle after the last word is accepted until the final length word is issued, `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Unit accepts an input word this cycle |
| in_data | input | 32 | Message word, byte 0 in bits 31:24 |
| in_last | input | 1 | This word ends the message |
| in_nbytes | input | 3 | Valid bytes in the last word (0 to 4) |
| msg_len_bits | input | 64 | Message length in bits, sampled with the last word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Engine accepts the output word |
| out_data | output | 32 | Padded message word |
| out_block_end | output | 1 | Output word is the 16th of its block |

## Verification
The block-slot counter is the most sensitive piece of state. If it is wrong, the length lands in the wrong slot and `out_block_end` goes out of step; both show on the first block of the next message and remain wrong from then on. A wrong padding state or a missed decision about whether the length still fits shows up in the same message as a missing or extra 16-word block, or as misplaced length words. A bad marker merge corrupts only the single word where the padding starts. Backpressure is applied in a regular pattern, so a hold error appears at the first stalled word.

// File: rtl/sha_pad_pkg.sv
package sha_pad_pkg;
  localparam int WORD_W = 32;
  localparam int BYTES  = WORD_W / 8;
  localparam int NB_W   = $clog2(BYTES + 1);
  localparam int LEN_W  = 2 * WORD_W;

  localparam logic [WORD_W-1:0] MARK_WORD = {8'h80, {(WORD_W-8){1'b0}}};

  typedef enum logic [2:0] {
    ST_PASS,
    ST_MARK,
    ST_ZERO,
    ST_LEN_HI,
    ST_LEN_LO
  } pad_state_e;
endpackage

// File: rtl/sha_pad_merge.sv
// Keeps the leading valid bytes of the final word, puts the 0x80 marker in
// the byte after them and clears the rest.
module sha_pad_merge
  import sha_pad_pkg::*;
(
  input  logic [WORD_W-1:0] data,
  input  logic [NB_W-1:0]   nbytes,
  output logic [WORD_W-1:0] word,
  output logic              full
);
  logic [7:0] lane [BYTES];

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign lane[i] = (NB_W'(i) < nbytes)  ? data[WORD_W-1-8*i -: 8] :
                     (NB_W'(i) == nbytes) ? 8'h80 : 8'h00;
    assign word[WORD_W-1-8*i -: 8] = lane[i];
  end

  assign full = (nbytes == NB_W'(BYTES));
endmodule

// File: rtl/sha_pad_slot_ctr.sv
// Slot position of the next output word within its block.
module sha_pad_slot_ctr #(
  parameter int BLK_WORDS = 16,
  localparam int CNT_W = $clog2(BLK_WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [CNT_W-1:0] slot,
  output logic             at_end
);
  assign at_end = (slot == CNT_W'(BLK_WORDS - 1));

  always_ff @(posedge clk) begin
    if (rst)
      slot <= '0;
    else if (step)
      slot <= at_end ? '0 : slot + 1'b1;
  end
endmodule

// File: rtl/sha_pad_unit.sv
module sha_pad_unit
  import sha_pad_pkg::*;
#(
  parameter int BLK_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_last,
  input  logic [NB_W-1:0]   in_nbytes,
  input  logic [LEN_W-1:0]  msg_len_bits,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_block_end
);
  localparam int CNT_W = $clog2(BLK_WORDS);
  localparam logic [CNT_W-1:0] LEN_SLOT = CNT_W'(BLK_WORDS - 2);
  localparam logic [CNT_W-1:0] TOP_SLOT = CNT_W'(BLK_WORDS - 1);

  pad_state_e         state_q, state_d;
  logic               fits_q, fits_d;
  logic [LEN_W-1:0]   len_q;
  logic [WORD_W-1:0]  word_d, merged;
  logic               merged_full;
  logic [CNT_W-1:0]   slot;
  logic               slot_end;
  logic               adv, take, load;

  sha_pad_merge u_merge (
    .data   (in_data),
    .nbytes (in_nbytes),
    .word   (merged),
    .full   (merged_full)
  );

  sha_pad_slot_ctr #(.BLK_WORDS(BLK_WORDS)) u_slot (
    .clk    (clk),
    .rst    (rst),
    .step   (load),
    .slot   (slot),
    .at_end (slot_end)
  );

  assign adv      = !out_valid || out_ready;
  assign in_ready = (state_q == ST_PASS) && adv;
  assign take     = in_valid && in_ready;
  assign load     = take || ((state_q != ST_PASS) && adv);

  // After the word that carries the marker: does the length still fit here?
  function automatic void after_marker(input logic [CNT_W-1:0] s,
                                       output pad_state_e nxt,
                                       output logic ok);
    ok  = (s < LEN_SLOT) || (s == TOP_SLOT);
    nxt = (s == LEN_SLOT - 1'b1) ? ST_LEN_HI : ST_ZERO;
  endfunction

  always_comb begin
    state_d = state_q;
    fits_d  = fits_q;
    word_d  = '0;
    unique case (state_q)
      ST_PASS: begin
        word_d = in_last ? merged : in_data;
        if (in_last) begin
          if (merged_full) begin
            word_d  = in_data;
            state_d = ST_MARK;
          end else begin
            after_marker(slot, state_d, fits_d);
          end
        end
      end
      ST_MARK: begin
        word_d = MARK_WORD;
        after_marker(slot, state_d, fits_d);
      end
      ST_ZERO: begin
        word_d = '0;
        if (slot_end)
          fits_d = 1'b1;
        if (fits_q && slot == LEN_SLOT - 1'b1)
          state_d = ST_LEN_HI;
      end
      ST_LEN_HI: begin
        word_d  = len_q[LEN_W-1:WORD_W];
        state_d = ST_LEN_LO;
      end
      ST_LEN_LO: begin
        word_d  = len_q[WORD_W-1:0];
        state_d = ST_PASS;
      end
      default: state_d = ST_PASS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_PASS;
      fits_q        <= 1'b0;
      len_q         <= '0;
      out_valid     <= 1'b0;
      out_data      <= '0;
      out_block_end <= 1'b0;
    end else if (load) begin
      state_q       <= state_d;
      fits_q        <= fits_d;
      out_valid     <= 1'b1;
      out_data      <= word_d;
      out_block_end <= slot_end;
      if (take && in_last)
        len_q <= msg_len_bits;
    end else if (adv) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sha_pad_check.sv
module sha_pad_check
  import sha_pad_pkg::*;
#(
  parameter int BLK_WORDS = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_last,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              out_block_end
);
  localparam int CNT_W = $clog2(BLK_WORDS);

  logic [CNT_W-1:0] hs_cnt;
  logic             rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst)
      hs_cnt <= '0;
    else if (out_valid && out_ready)
      hs_cnt <= hs_cnt + 1'b1;
  end

  assert_idle_after_reset_R1: assert property (@(posedge clk)
    rst_d |-> !out_valid);

  assert_block_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |->
      (out_block_end == (hs_cnt == CNT_W'(BLK_WORDS - 1))));

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_block_end)));

  assert_no_input_while_padding_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> !in_ready);
endmodule

bind sha_pad_unit sha_pad_check #(.BLK_WORDS(BLK_WORDS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_last       (in_last),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_data      (out_data),
  .out_block_end (out_block_end)
);

// File: tb/sim_sha_pad_unit.sv
`timescale 1ns/1ps
module sim_sha_pad_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        in_last = 1'b0;
  logic [2:0]  in_nbytes = '0;
  logic [63:0] msg_len_bits = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_block_end;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int got_words = 0;
  int out_index = 0;
  bit stall = 1'b0;
  bit done  = 1'b0;

  logic [31:0] exp_w[$];
  string       exp_tag[$];

  always #10 clk = ~clk;

  sha_pad_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_nbytes(in_nbytes),
    .msg_len_bits(msg_len_bits), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_block_end(out_block_end)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "ALL", "watchdog expired", 64'(cyc), 64'd0);
      finish_run();
    end
  end

  // Output monitor: drives out_ready, compares every accepted word.
  initial begin
    bit          hold_pending = 1'b0;
    logic [31:0] hold_data = '0;
    logic        hold_be = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = stall ? (cyc % 3 != 0) : 1'b1;
      #2;
      if (hold_pending) begin
        chk(out_valid === 1'b1 && out_data === hold_data && out_block_end === hold_be,
            "R9", "stalled word held", {31'd0, out_valid, out_data}, {32'd1, hold_data});
        hold_pending = 1'b0;
      end
      if (out_valid === 1'b1 && out_ready) begin
        got_words++;
        if (exp_w.size() == 0) begin
          chk(1'b0, "R6", "unexpected extra word", 64'(out_data), 64'd0);
        end else begin
          logic [31:0] ew;
          string       et;
          ew = exp_w.pop_front();
          et = exp_tag.pop_front();
          chk(out_data === ew, et, "output word", 64'(out_data), 64'(ew));
        end
        chk(out_block_end === (out_index % 16 == 15), "R8", "block end flag",
            64'(out_block_end), 64'(out_index % 16 == 15));
        out_index++;
      end else if (out_valid === 1'b1) begin
        hold_pending = 1'b1;
        hold_data = out_data;
        hold_be = out_block_end;
      end
    end
  end

  function automatic logic [7:0] msg_byte(int seed, int k);
    return 8'((seed + k * 7 + 1) & 8'hFF);
  endfunction

  // Builds the expected padded stream from the padding rules.
  task automatic expect_msg(input int n, input int seed, input logic [63:0] len);
    logic [7:0] pad[$];
    int nw;
    for (int k = 0; k < n; k++) pad.push_back(msg_byte(seed, k));
    pad.push_back(8'h80);
    while (pad.size() % 64 != 56) pad.push_back(8'h00);
    for (int k = 7; k >= 0; k--) pad.push_back(len[8*k +: 8]);
    nw = pad.size() / 4;
    for (int i = 0; i < nw; i++) begin
      string t;
      exp_w.push_back({pad[4*i], pad[4*i+1], pad[4*i+2], pad[4*i+3]});
      if (4 * i + 4 <= n)       t = "R2";
      else if (i == n / 4)      t = (n == 0) ? "R5" : ((n % 4 == 0) ? "R4" : "R3");
      else if (i >= nw - 2)     t = "R7";
      else                      t = "R6";
      exp_tag.push_back(t);
    end
  endtask

  task automatic run_msg(input string name, input int n, input int seed,
                         input logic [63:0] len, input bit use_stall);
    int nwords, exp_count, t;
    exp_count = 0;
    stall = use_stall;
    expect_msg(n, seed, len);
    exp_count = exp_w.size();
    got_words = 0;
    nwords = (n == 0) ? 1 : (n + 3) / 4;
    for (int w = 0; w < nwords; w++) begin
      bit lastw;
      int nb;
      lastw = (w == nwords - 1);
      nb = lastw ? (n - 4 * w) : 4;
      @(negedge clk);
      in_valid = 1'b1;
      in_last  = lastw;
      in_nbytes = 3'(nb);
      msg_len_bits = lastw ? len : 64'hDEAD_BEEF_0BAD_F00D;
      for (int b = 0; b < 4; b++)
        in_data[31-8*b -: 8] = (b < nb) ? msg_byte(seed, 4 * w + b) : 8'hC3;
      #1;
      while (in_ready !== 1'b1) begin
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_data = 32'h5A5A_5A5A;
    msg_len_bits = ~len;
    #1;
    chk(in_ready === 1'b0, "R10", {name, " input blocked during padding"},
        64'(in_ready), 64'd0);
    t = 0;
    while (exp_w.size() != 0 && t < 4000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    chk(got_words == exp_count, "R6", {name, " padded length in words"},
        64'(got_words), 64'(exp_count));
    exp_w.delete();
    exp_tag.delete();
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(out_valid === 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
    chk(in_ready === 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);
  endtask

  initial begin
    test_reset();
    run_msg("empty", 0, 0, 64'd0, 1'b0);
    run_msg("one byte", 1, 3, 64'd8, 1'b0);
    run_msg("two bytes", 2, 9, 64'd16, 1'b0);
    run_msg("three bytes", 3, 21, 64'd24, 1'b1);
    run_msg("one word", 4, 40, 64'd32, 1'b0);
    run_msg("55 bytes", 55, 5, 64'd440, 1'b0);
    run_msg("56 bytes", 56, 6, 64'd448, 1'b1);
    run_msg("58 bytes", 58, 8, 64'd464, 1'b0);
    run_msg("60 bytes", 60, 11, 64'd480, 1'b0);
    run_msg("64 bytes", 64, 13, 64'd512, 1'b1);
    run_msg("130 bytes", 130, 17, 64'd1040, 1'b1);
    run_msg("override length", 20, 29, 64'h0000_0001_0000_02A0, 1'b0);
    run_msg("119 bytes", 119, 33, 64'd952, 1'b1);
    done = 1'b1;
    finish_run();
  end
endmodule